// File: doc/BRIEF.md
# Trap return state restorer

This block performs the two trap-return operations of a processor core: "done", which resumes after the trapping instruction, and "retry", which re-executes it. A request makes the block read the saved trap record for the current trap level from an external trap stack with a synchronous read port. The record holds the saved program counter, the saved next program counter and a packed 40-bit saved-state word. From that record the block restores the program counters, the condition codes, the address space identifier, the processor state word and the current window pointer. It then lowers the trap level by one and emits a pulse that asks the interrupt logic to re-evaluate pending interrupts.

The block also owns the global register file. That file holds four banks of global registers, and the bank in use follows the bank-select bits of the processor state word. A restore that changes those bits changes the visible bank. A request made at trap level zero is refused with an error pulse.

A restore takes three clock cycles from request to completion. Requests that arrive while a restore is in progress are dropped.

Top module: `tr_restore`

## Requirements
- R1: After reset, pc, npc, condition codes, asi, pstate, cwp, trap level and bank select are all zero, and busy, ret_done, irq_reeval, err_tl0 and ts_rd_en are low.
- R2: A request with ret_kind=0 (done) sets pc to the saved next PC and npc to the saved next PC plus 4.
- R3: A request with ret_kind=1 (retry) sets pc to the saved PC and npc to the saved next PC.
- R4: The saved-state bits 39:36 become ccr_xcc (the 64-bit flags), bits 35:32 become ccr_icc (the 32-bit flags), and bits 31:24 become asi.
- R5: pstate becomes saved-state bits 19:8 ANDed with 0xF3F. When HAS_GL=1, pstate bit 0 is also forced to 0.
- R6: Let v be saved-state bits 7:0. cwp becomes NWIN-1-(v mod NWIN).
- R7: ts_rd_en is high for exactly the one cycle after an accepted request, with ts_rd_addr equal to the trap level minus 1. The trap level drops by one when the restore completes.
- R8: A request at trap level 0 raises err_tl0 for one cycle, starting one cycle after the request. It issues no read and changes no architectural output.
- R9: The bank is chosen from pstate bits as follows: bit 0 alone selects bank 1, bit 10 alone selects bank 2, bit 11 alone selects bank 3, and any other combination selects bank 0. Global register reads and writes use the active bank, and every bank keeps its contents.
- R10: ret_done and irq_reeval are each high for exactly one cycle, namely the cycle after the restore takes effect, which is three cycles after the request.
- R11: While busy, further requests and trap level writes are ignored. A trap level write made while idle with no request present loads the written value, capped at MAXTL.
- R12: A global register write in the cycle in which a restore takes effect lands in the bank that was active before the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_req | input | 1 | Trap-return request, one cycle |
| ret_kind | input | 1 | 0 = done, 1 = retry |
| tl_wr_en | input | 1 | Load trap level |
| tl_wr_val | input | TL_W | Trap level to load |
| ts_rd_en | output | 1 | Trap stack read strobe |
| ts_rd_addr | output | ADDR_W | Trap stack entry index (level minus 1) |
| ts_rd_tpc | input | XLEN | Saved PC, valid the cycle after the strobe |
| ts_rd_tnpc | input | XLEN | Saved next PC |
| ts_rd_tstate | input | 40 | Saved packed state word |
| gr_wr_en | input | 1 | Global register write enable |
| gr_wr_idx | input | GIDX_W | Global register write index |
| gr_wr_data | input | XLEN | Global register write data |
| gr_rd_idx | input | GIDX_W | Global register read index |
| gr_rd_data | output | XLEN | Global register read data, one cycle latency |
| pc | output | XLEN | Program counter |
| npc | output | XLEN | Next program counter |
| ccr_xcc | output | 4 | 64-bit condition flags |
| ccr_icc | output | 4 | 32-bit condition flags |
| asi | output | 8 | Address space identifier |
| pstate | output | 12 | Processor state word |
| cwp | output | CWP_W | Current window pointer |
| tl | output | TL_W | Trap level |
| gbank_sel | output | 2 | Active global bank |
| busy | output | 1 | Restore in progress |
| ret_done | output | 1 | Restore completed pulse |
| irq_reeval | output | 1 | Interrupt re-evaluation pulse |
| err_tl0 | output | 1 | Request refused at trap level 0 |

## Verification
The collision that matters is between a global register write and a restore that changes the bank. Both can fall on the final edge of a restore. The bench provokes this by asserting a write exactly in the cycle that applies a restore leaving bank 1 for bank 0. It then reads the same index in both banks: the new value must sit in bank 1, and bank 0 must keep its older value. A second overlap sends a fresh request and a trap level write during a restore in progress. The bench judges this by counting completion pulses and by reading the final trap level.

// File: rtl/tr_pkg.sv
package tr_pkg;

  typedef enum logic {
    RET_DONE  = 1'b0,
    RET_RETRY = 1'b1
  } ret_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_READ = 2'd1,
    S_WAIT = 2'd2
  } rst_state_e;

  localparam int TSTATE_W = 40;
  localparam logic [11:0] PSTATE_KEEP = 12'hF3F;
  localparam int PS_ALT_BIT = 0;
  localparam int PS_MMU_BIT = 10;
  localparam int PS_INT_BIT = 11;
  localparam int NBANK = 4;

  typedef struct packed {
    logic [3:0]  xcc;
    logic [3:0]  icc;
    logic [7:0]  asi;
    logic [3:0]  spare;
    logic [11:0] pstate;
    logic [7:0]  cwp_raw;
  } tstate_t;

  function automatic logic [1:0] bank_of(input logic [11:0] ps);
    logic a, m, i;
    a = ps[PS_ALT_BIT];
    m = ps[PS_MMU_BIT];
    i = ps[PS_INT_BIT];
    case ({i, m, a})
      3'b001:  return 2'd1;
      3'b010:  return 2'd2;
      3'b100:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/tr_unpack.sv
module tr_unpack
  import tr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NWIN   = 8,
  parameter int CWP_W  = 3,
  parameter bit HAS_GL = 1'b0
) (
  input  logic                kind,
  input  logic [XLEN-1:0]     tpc,
  input  logic [XLEN-1:0]     tnpc,
  input  logic [TSTATE_W-1:0] tstate,
  output logic [XLEN-1:0]     new_pc,
  output logic [XLEN-1:0]     new_npc,
  output logic [3:0]          new_xcc,
  output logic [3:0]          new_icc,
  output logic [7:0]          new_asi,
  output logic [11:0]         new_pstate,
  output logic [CWP_W-1:0]    new_cwp
);

  tstate_t    fields;
  logic [7:0] wrapped;
  logic [11:0] masked;
  logic [3:0] unused_spare;

  assign fields       = tstate_t'(tstate);
  assign unused_spare = fields.spare;

  always_comb begin
    if (kind == RET_RETRY) begin
      new_pc  = tpc;
      new_npc = tnpc;
    end else begin
      new_pc  = tnpc;
      new_npc = tnpc + XLEN'(4);
    end
  end

  assign new_xcc = fields.xcc;
  assign new_icc = fields.icc;
  assign new_asi = fields.asi;
  assign masked  = fields.pstate & PSTATE_KEEP;

  generate
    if (HAS_GL) begin : g_gl
      assign new_pstate = masked & ~(12'd1 << PS_ALT_BIT);
    end else begin : g_nogl
      assign new_pstate = masked;
    end
  endgenerate

  assign wrapped = fields.cwp_raw % 8'(NWIN);
  assign new_cwp = CWP_W'(8'(NWIN - 1) - wrapped);

endmodule

// File: rtl/tr_ctrl.sv
module tr_ctrl
  import tr_pkg::*;
#(
  parameter int MAXTL  = 4,
  parameter int TL_W   = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              kind,
  input  logic              tl_wr_en,
  input  logic [TL_W-1:0]   tl_wr_val,
  output logic [TL_W-1:0]   tl,
  output logic              ts_rd_en,
  output logic [ADDR_W-1:0] ts_rd_addr,
  output logic              apply,
  output logic              kind_q,
  output logic              busy,
  output logic              err_tl0
);

  rst_state_e st;

  assign apply = (st == S_WAIT);
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      tl         <= '0;
      ts_rd_en   <= 1'b0;
      ts_rd_addr <= '0;
      kind_q     <= RET_DONE;
      err_tl0    <= 1'b0;
    end else begin
      err_tl0  <= 1'b0;
      ts_rd_en <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            if (tl == '0) begin
              err_tl0 <= 1'b1;
            end else begin
              st         <= S_READ;
              ts_rd_en   <= 1'b1;
              ts_rd_addr <= ADDR_W'(tl - TL_W'(1));
              kind_q     <= kind;
            end
          end else if (tl_wr_en) begin
            tl <= (tl_wr_val > TL_W'(MAXTL)) ? TL_W'(MAXTL) : tl_wr_val;
          end
        end
        S_READ:  st <= S_WAIT;
        S_WAIT: begin
          st <= S_IDLE;
          tl <= tl - TL_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TL_STEP: assert property (@(posedge clk) disable iff (rst)
    apply |=> (tl == $past(tl) - TL_W'(1)));  // R7
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ts_rd_en |=> !ts_rd_en);  // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_tl0 |-> (tl == '0 && !ts_rd_en && !busy));  // R8
  AST_TL_CAP: assert property (@(posedge clk) disable iff (rst)
    tl <= TL_W'(MAXTL));  // R11

endmodule

// File: rtl/tr_gbank.sv
module tr_gbank
  import tr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int GIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [11:0]       new_pstate,
  input  logic              wr_en,
  input  logic [GIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [GIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic [1:0]        bank
);

  localparam int DEPTH = NBANK * (1 << GIDX_W);

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{bank, wr_idx}] <= wr_data;
    rd_data <= mem[{bank, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst)        bank <= 2'd0;
    else if (apply) bank <= bank_of(new_pstate);
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(bank));  // R9

endmodule

// File: rtl/tr_restore.sv
module tr_restore
  import tr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NWIN   = 8,
  parameter int MAXTL  = 4,
  parameter int GREGS  = 8,
  parameter bit HAS_GL = 1'b0,
  localparam int TL_W   = $clog2(MAXTL + 1),
  localparam int ADDR_W = (MAXTL > 1) ? $clog2(MAXTL) : 1,
  localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int GIDX_W = (GREGS > 1) ? $clog2(GREGS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ret_req,
  input  logic                ret_kind,
  input  logic                tl_wr_en,
  input  logic [TL_W-1:0]     tl_wr_val,
  output logic                ts_rd_en,
  output logic [ADDR_W-1:0]   ts_rd_addr,
  input  logic [XLEN-1:0]     ts_rd_tpc,
  input  logic [XLEN-1:0]     ts_rd_tnpc,
  input  logic [TSTATE_W-1:0] ts_rd_tstate,
  input  logic                gr_wr_en,
  input  logic [GIDX_W-1:0]   gr_wr_idx,
  input  logic [XLEN-1:0]     gr_wr_data,
  input  logic [GIDX_W-1:0]   gr_rd_idx,
  output logic [XLEN-1:0]     gr_rd_data,
  output logic [XLEN-1:0]     pc,
  output logic [XLEN-1:0]     npc,
  output logic [3:0]          ccr_xcc,
  output logic [3:0]          ccr_icc,
  output logic [7:0]          asi,
  output logic [11:0]         pstate,
  output logic [CWP_W-1:0]    cwp,
  output logic [TL_W-1:0]     tl,
  output logic [1:0]          gbank_sel,
  output logic                busy,
  output logic                ret_done,
  output logic                irq_reeval,
  output logic                err_tl0
);

  logic             apply;
  logic             kind_q;
  logic [XLEN-1:0]  n_pc, n_npc;
  logic [3:0]       n_xcc, n_icc;
  logic [7:0]       n_asi;
  logic [11:0]      n_pstate;
  logic [CWP_W-1:0] n_cwp;

  tr_ctrl #(.MAXTL(MAXTL), .TL_W(TL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .req(ret_req), .kind(ret_kind),
    .tl_wr_en(tl_wr_en), .tl_wr_val(tl_wr_val), .tl(tl),
    .ts_rd_en(ts_rd_en), .ts_rd_addr(ts_rd_addr), .apply(apply),
    .kind_q(kind_q), .busy(busy), .err_tl0(err_tl0)
  );

  tr_unpack #(.XLEN(XLEN), .NWIN(NWIN), .CWP_W(CWP_W), .HAS_GL(HAS_GL)) u_unpack (
    .kind(kind_q), .tpc(ts_rd_tpc), .tnpc(ts_rd_tnpc), .tstate(ts_rd_tstate),
    .new_pc(n_pc), .new_npc(n_npc), .new_xcc(n_xcc), .new_icc(n_icc),
    .new_asi(n_asi), .new_pstate(n_pstate), .new_cwp(n_cwp)
  );

  tr_gbank #(.XLEN(XLEN), .GIDX_W(GIDX_W)) u_gbank (
    .clk(clk), .rst(rst), .apply(apply), .new_pstate(n_pstate),
    .wr_en(gr_wr_en), .wr_idx(gr_wr_idx), .wr_data(gr_wr_data),
    .rd_idx(gr_rd_idx), .rd_data(gr_rd_data), .bank(gbank_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      npc        <= '0;
      ccr_xcc    <= '0;
      ccr_icc    <= '0;
      asi        <= '0;
      pstate     <= '0;
      cwp        <= '0;
      ret_done   <= 1'b0;
      irq_reeval <= 1'b0;
    end else begin
      ret_done   <= apply;
      irq_reeval <= apply;
      if (apply) begin
        pc      <= n_pc;
        npc     <= n_npc;
        ccr_xcc <= n_xcc;
        ccr_icc <= n_icc;
        asi     <= n_asi;
        pstate  <= n_pstate;
        cwp     <= n_cwp;
      end
    end
  end

  AST_DONE_NPC: assert property (@(posedge clk) disable iff (rst)
    (ret_done && kind_q == RET_DONE) |-> (npc == pc + XLEN'(4)));  // R2
  AST_PSTATE_HOLES: assert property (@(posedge clk) disable iff (rst)
    ((pstate & ~PSTATE_KEEP) == 12'd0) && !(HAS_GL && pstate[PS_ALT_BIT]));  // R5
  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cwp) < NWIN);  // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ret_done |=> !ret_done && !irq_reeval);  // R10
  AST_PC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ret_done |-> ($stable(pc) && $stable(pstate)));  // R11

endmodule

// File: tb/tr_restore_tb_top.sv
`timescale 1ns/1ps
module tr_restore_tb_top;

  localparam int XLEN = 64;
  localparam int NWIN = 8;
  localparam int MAXTL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        ret_req = 0, ret_kind = 0, tl_wr_en = 0;
  logic [2:0]  tl_wr_val = 0;
  logic        gr_wr_en = 0;
  logic [2:0]  gr_wr_idx = 0, gr_rd_idx = 0;
  logic [63:0] gr_wr_data = 0;

  logic        ts_rd_en, g_rd_en;
  logic [1:0]  ts_rd_addr, g_rd_addr;
  logic [63:0] q_tpc, q_tnpc;
  logic [39:0] q_tstate;
  logic [63:0] m_tpc [MAXTL];
  logic [63:0] m_tnpc [MAXTL];
  logic [39:0] m_tstate [MAXTL];

  logic [63:0] gr_rd_data, pc, npc, g_rd_data, g_pc, g_npc;
  logic [3:0]  xcc, icc, g_xcc, g_icc;
  logic [7:0]  asi, g_asi;
  logic [11:0] pstate, g_pstate;
  logic [2:0]  cwp, tl, g_cwp, g_tl;
  logic [1:0]  gbank, g_gbank;
  logic        busy, ret_done, irq_reeval, err_tl0;
  logic        g_busy, g_done, g_irq, g_err;

  always_ff @(posedge clk) if (ts_rd_en) begin
    q_tpc    <= m_tpc[ts_rd_addr];
    q_tnpc   <= m_tnpc[ts_rd_addr];
    q_tstate <= m_tstate[ts_rd_addr];
  end

  tr_restore #(.XLEN(XLEN), .NWIN(NWIN), .MAXTL(MAXTL), .HAS_GL(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ret_req(ret_req), .ret_kind(ret_kind),
    .tl_wr_en(tl_wr_en), .tl_wr_val(tl_wr_val), .ts_rd_en(ts_rd_en),
    .ts_rd_addr(ts_rd_addr), .ts_rd_tpc(q_tpc), .ts_rd_tnpc(q_tnpc),
    .ts_rd_tstate(q_tstate), .gr_wr_en(gr_wr_en), .gr_wr_idx(gr_wr_idx),
    .gr_wr_data(gr_wr_data), .gr_rd_idx(gr_rd_idx), .gr_rd_data(gr_rd_data),
    .pc(pc), .npc(npc), .ccr_xcc(xcc), .ccr_icc(icc), .asi(asi),
    .pstate(pstate), .cwp(cwp), .tl(tl), .gbank_sel(gbank), .busy(busy),
    .ret_done(ret_done), .irq_reeval(irq_reeval), .err_tl0(err_tl0)
  );

  tr_restore #(.XLEN(XLEN), .NWIN(NWIN), .MAXTL(MAXTL), .HAS_GL(1'b1)) dut_gl (
    .clk(clk), .rst(rst), .ret_req(ret_req), .ret_kind(ret_kind),
    .tl_wr_en(tl_wr_en), .tl_wr_val(tl_wr_val), .ts_rd_en(g_rd_en),
    .ts_rd_addr(g_rd_addr), .ts_rd_tpc(q_tpc), .ts_rd_tnpc(q_tnpc),
    .ts_rd_tstate(q_tstate), .gr_wr_en(gr_wr_en), .gr_wr_idx(gr_wr_idx),
    .gr_wr_data(gr_wr_data), .gr_rd_idx(gr_rd_idx), .gr_rd_data(g_rd_data),
    .pc(g_pc), .npc(g_npc), .ccr_xcc(g_xcc), .ccr_icc(g_icc), .asi(g_asi),
    .pstate(g_pstate), .cwp(g_cwp), .tl(g_tl), .gbank_sel(g_gbank), .busy(g_busy),
    .ret_done(g_done), .irq_reeval(g_irq), .err_tl0(g_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_bank(input logic [11:0] ps);
    int cnt;
    cnt = int'(ps[0]) + int'(ps[10]) + int'(ps[11]);
    if (cnt != 1) return 2'd0;
    if (ps[0]) return 2'd1;
    if (ps[10]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic set_tl(input logic [2:0] v);
    @(negedge clk); tl_wr_en = 1; tl_wr_val = v;
    @(posedge clk); @(negedge clk); tl_wr_en = 0;
  endtask

  task automatic do_ret(input logic k, input logic [2:0] tl_now);
    @(negedge clk); ret_req = 1; ret_kind = k;
    @(posedge clk); @(negedge clk); ret_req = 0;
    chk("R7 rd_en", 64'(ts_rd_en), 64'd1);
    chk("R7 rd_addr", 64'(ts_rd_addr), 64'(tl_now - 3'd1));
    @(posedge clk); @(negedge clk);
    chk("R10 early", 64'(ret_done), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 done", 64'(ret_done), 64'd1);
    chk("R10 irq", 64'(irq_reeval), 64'd1);
  endtask

  task automatic gr_write(input logic [2:0] idx, input logic [63:0] d);
    @(negedge clk); gr_wr_en = 1; gr_wr_idx = idx; gr_wr_data = d;
    @(posedge clk); @(negedge clk); gr_wr_en = 0;
  endtask

  task automatic gr_read(input logic [2:0] idx, output logic [63:0] d);
    @(negedge clk); gr_rd_idx = idx;
    @(posedge clk); @(negedge clk); d = gr_rd_data;
  endtask

  task automatic load_ps(input logic [11:0] ps);
    m_tpc[0] = 64'h100; m_tnpc[0] = 64'h104;
    m_tstate[0] = {16'h0, 4'h0, ps, 8'h0};
    set_tl(3'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, 0); chk("R1 npc", npc, 0);
    chk("R1 pstate", 64'(pstate), 0); chk("R1 cwp", 64'(cwp), 0);
    chk("R1 tl", 64'(tl), 0); chk("R1 bank", 64'(gbank), 0);
    chk("R1 flags", 64'({busy, ret_done, irq_reeval, err_tl0, ts_rd_en}), 0);

    // R8 request at trap level zero
    @(negedge clk); ret_req = 1; ret_kind = 0;
    @(posedge clk); @(negedge clk); ret_req = 0;
    chk("R8 err", 64'(err_tl0), 1); chk("R8 no read", 64'(ts_rd_en), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 err pulse", 64'(err_tl0), 0);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 no done", 64'(ret_done), 0); chk("R8 pc", pc, 0); chk("R8 tl", 64'(tl), 0);

    // R11 trap level cap
    set_tl(3'd7);
    chk("R11 cap", 64'(tl), 64'(MAXTL));

    // sweep: level x kind x window field
    for (int t = 1; t <= MAXTL; t++) begin
      for (int k = 0; k < 2; k++) begin
        for (int c = 0; c < 16; c++) begin
          logic [63:0] tp, tn;
          logic [7:0]  cc, as, raw;
          logic [11:0] ps, eps;
          tp = 64'h1000_0000_0000_0000 + 64'(t * 256 + k * 16 + c);
          tn = tp * 3 + 64'h40;
          cc = 8'(c * 17 + t);
          as = 8'(c * 13 + k * 7);
          ps = 12'(c * 419 + t * 97 + k * 1031);
          raw = 8'(c + 240 * k);
          m_tpc[t-1] = tp; m_tnpc[t-1] = tn;
          m_tstate[t-1] = {cc, as, 4'(c), ps, raw};
          set_tl(3'(t));
          do_ret(k[0], 3'(t));
          chk(k ? "R3 pc" : "R2 pc", pc, k ? tp : tn);
          chk(k ? "R3 npc" : "R2 npc", npc, k ? tn : tn + 64'd4);
          chk("R4 xcc", 64'(xcc), 64'(cc[7:4]));
          chk("R4 icc", 64'(icc), 64'(cc[3:0]));
          chk("R4 asi", 64'(asi), 64'(as));
          eps = ps & 12'hF3F;
          chk("R5 pstate", 64'(pstate), 64'(eps));
          chk("R5 gl pstate", 64'(g_pstate), 64'(eps & 12'hF3E));
          chk("R6 cwp", 64'(cwp), 64'(NWIN - 1 - (int'(raw) % NWIN)));
          chk("R7 tl", 64'(tl), 64'(t - 1));
          chk("R9 bank", 64'(gbank), 64'(exp_bank(eps)));
          chk("R9 gl bank", 64'(g_gbank), 64'(exp_bank(eps & 12'hF3E)));
          @(negedge clk);
          chk("R10 pulse end", 64'({ret_done, irq_reeval}), 0);
        end
      end
    end

    // R11 requests and level writes during a restore
    begin
      int dones;
      m_tpc[2] = 64'hA0; m_tnpc[2] = 64'hB0; m_tstate[2] = 40'h0;
      set_tl(3'd3);
      @(negedge clk); ret_req = 1; ret_kind = 1;
      @(posedge clk); @(negedge clk); ret_kind = 0; tl_wr_en = 1; tl_wr_val = 3'd1;
      dones = 0;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk); @(negedge clk);
        if (i == 0) begin ret_req = 0; tl_wr_en = 0; end
        dones += int'(ret_done);
      end
      chk("R11 one done", 64'(dones), 1);
      chk("R11 tl", 64'(tl), 2);
      chk("R11 kind kept", pc, 64'hA0);
    end

    // R9 / R12 bank contents and collision
    load_ps(12'h000); do_ret(1'b0, 3'd1);
    gr_write(3'd5, 64'hB0);
    load_ps(12'h001); do_ret(1'b0, 3'd1);
    chk("R9 alt bank", 64'(gbank), 1);
    gr_write(3'd5, 64'hB1);
    gr_read(3'd5, rv); chk("R9 read b1", rv, 64'hB1);
    load_ps(12'h000);
    @(negedge clk); ret_req = 1; ret_kind = 0;
    @(posedge clk); @(negedge clk); ret_req = 0;
    @(posedge clk); @(negedge clk);
    gr_wr_en = 1; gr_wr_idx = 3'd5; gr_wr_data = 64'hC1;
    @(posedge clk); @(negedge clk); gr_wr_en = 0;
    chk("R9 back to 0", 64'(gbank), 0);
    gr_read(3'd5, rv); chk("R12 bank0 kept", rv, 64'hB0);
    load_ps(12'h001); do_ret(1'b0, 3'd1);
    gr_read(3'd5, rv); chk("R12 write in old bank", rv, 64'hC1);
    load_ps(12'h400); do_ret(1'b0, 3'd1);
    chk("R9 mmu bank", 64'(gbank), 2);
    load_ps(12'h800); do_ret(1'b0, 3'd1);
    chk("R9 int bank", 64'(gbank), 3);
    load_ps(12'hC01); do_ret(1'b0, 3'd1);
    chk("R9 multi bank", 64'(gbank), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule